// File: doc/BRIEF.md
# Load/Store Hazard Dependency Matrix

This block keeps memory operations that are in flight in a scoreboard-style core in the right order with respect to each other. It has a fixed set of slots. Each accepted load or store takes the lowest-numbered free slot. The slot stores the operation's kind and a coarse address tag, which is the address with its line-offset bits removed.

When an operation is issued, its tag is compared against every occupied slot that holds the opposite kind. Every slot that matches sets a bit in the new slot's dependency row. Matching is conservative: it tells only that a clash cannot be ruled out. Two loads never wait on each other, and neither do two stores.

When an operation completes, its slot is released and its column is wiped from every row. Each slot drives a read permission if it holds a load, or a write permission if it holds a store. A permission is high only when that slot's row is empty. These permissions feed the function-unit dependency matrix.

Each slot runs a small state machine with three states:
- `SL_FREE`: the slot is empty.
- `SL_WAIT`: the slot is occupied and its row has at least one bit set.
- `SL_GO`: the slot is occupied and its row is clear.

The transitions are:
- alloc-blocked: `SL_FREE`→`SL_WAIT`.
- alloc-clear: `SL_FREE`→`SL_GO`.
- deps-drained: `SL_WAIT`→`SL_GO`.
- retire: `SL_WAIT` or `SL_GO`→`SL_FREE`, on a completion for this slot.
- hold: any state stays as it is when none of the above applies.

Top module: `ldst_hazard_matrix`

## Requirements
- R1: A synchronous active-high reset returns every slot to `SL_FREE`. After reset `slot_busy`, `go_read` and `go_write` are all zero, and `iss_stall` is low while `iss_valid` is low.
- R2: `iss_slot` shows the lowest-numbered free slot combinationally. An issue that is accepted makes that slot busy from the following cycle.
- R3: A load that is issued while a store with the same tag is occupying a slot gets a dependency on that store. Its `go_read` stays low.
- R4: A store that is issued while a load with the same tag is occupying a slot gets a dependency on that load. Its `go_write` stays low.
- R5: The tag is `iss_addr[ADDR_W-1:LINE_BITS]`. Addresses that differ only below bit LINE_BITS count as a conflict. Addresses whose tags differ never count as one.
- R6: Operations of the same kind never depend on each other, even when their tags match.
- R7: A completion (`done_valid` with binary index `done_slot`) on a busy slot frees that slot and clears its column. A slot that depended only on it raises its permission in the cycle after the completion edge.
- R8: A permission is raised only once every dependency bit in the slot's row has cleared.
- R9: When all slots are busy, `iss_valid` raises `iss_stall` and the operation is not taken. A completion in the same cycle does not lift the stall.
- R10: A completion whose index names a free slot has no effect.
- R11: If an issue and a completion happen in the same cycle, the new operation takes no dependency on the slot that is completing.
- R12: `go_read` is only ever high for a slot holding a load (`iss_is_store`=0). `go_write` is only ever high for a slot holding a store (`iss_is_store`=1). The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_is_store | input | 1 | 1 = store, 0 = load |
| iss_addr | input | ADDR_W | Operation address |
| iss_stall | output | 1 | Issue refused because every slot is busy |
| iss_slot | output | IDX_W | Slot the issue will take |
| done_valid | input | 1 | Completion strobe |
| done_slot | input | IDX_W | Index of the slot that is completing |
| slot_busy | output | NSLOT | Occupancy per slot |
| go_read | output | NSLOT | Read permission per slot |
| go_write | output | NSLOT | Write permission per slot |

## Verification
The assertions assume that `iss_addr` and `iss_is_store` are stable and known whenever `iss_valid` is high. They also assume that `done_slot` stays below NSLOT while `done_valid` is high. The bench drives every input only at the falling edge of the clock and keeps every `done_slot` in range. It issues completions to free slots only on purpose, to exercise R10. Addresses are picked so that each tag match or mismatch is unambiguous, including pairs that sit right at a line boundary.

// File: rtl/ldst_hm_pkg.sv
package ldst_hm_pkg;
    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_WAIT = 2'd1,
        SL_GO   = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ldst_hm_alloc.sv
module ldst_hm_alloc #(
    parameter int NSLOT = 8,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [NSLOT-1:0] busy,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ldst_hm_cmp.sv
module ldst_hm_cmp #(
    parameter int NSLOT = 8,
    parameter int TAG_W = 26
) (
    input  logic [NSLOT-1:0] busy,
    input  logic [NSLOT-1:0] is_store,
    input  logic [TAG_W-1:0] tags [NSLOT],
    input  logic [NSLOT-1:0] clr_col,
    input  logic             new_store,
    input  logic [TAG_W-1:0] new_tag,
    output logic [NSLOT-1:0] dep_row
);
    for (genvar j = 0; j < NSLOT; j++) begin : g_col
        logic kind_differs;
        logic tag_hit;
        assign kind_differs = is_store[j] ^ new_store;
        assign tag_hit      = (tags[j] == new_tag);
        assign dep_row[j]   = busy[j] & kind_differs & tag_hit & ~clr_col[j];
    end
endmodule

// File: rtl/ldst_hm_slot.sv
module ldst_hm_slot
    import ldst_hm_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic             alloc_store,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [NSLOT-1:0] alloc_row,
    input  logic [NSLOT-1:0] clr_col,
    input  logic             done_hit,
    output logic             busy,
    output logic             is_store,
    output logic [TAG_W-1:0] tag,
    output logic [NSLOT-1:0] row,
    output logic             go_rd,
    output logic             go_wr
);
    slot_state_e      state_q, state_d;
    logic [NSLOT-1:0] row_q, row_d;
    logic             store_q, store_d;
    logic [TAG_W-1:0] tag_q, tag_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SL_FREE;
            row_q   <= '0;
            store_q <= 1'b0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            store_q <= store_d;
            tag_q   <= tag_d;
        end
    end

    always_comb begin
        state_d = state_q;
        row_d   = row_q & ~clr_col;
        store_d = store_q;
        tag_d   = tag_q;
        unique case (state_q)
            SL_FREE: begin
                row_d = '0;
                if (alloc_en) begin
                    row_d   = alloc_row & ~clr_col;
                    store_d = alloc_store;
                    tag_d   = alloc_tag;
                    state_d = (row_d == '0) ? SL_GO : SL_WAIT;
                end
            end
            SL_WAIT: begin
                if (done_hit) begin
                    state_d = SL_FREE;
                    row_d   = '0;
                end else if (row_d == '0) begin
                    state_d = SL_GO;
                end
            end
            SL_GO: begin
                if (done_hit) begin
                    state_d = SL_FREE;
                    row_d   = '0;
                end
            end
            default: begin
                state_d = SL_FREE;
                row_d   = '0;
            end
        endcase
    end

    always_comb begin
        busy     = (state_q != SL_FREE);
        is_store = store_q;
        tag      = tag_q;
        row      = row_q;
        go_rd    = (state_q == SL_GO) && !store_q;
        go_wr    = (state_q == SL_GO) && store_q;
    end

    AST_GO_ROW_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (go_rd || go_wr) |-> (row_q == '0)); // R8
    AST_PERMIT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(go_rd && go_wr)); // R12
    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (rst)
        done_hit |=> !busy); // R7
    AST_NO_LATE_DEP: assert property (@(posedge clk) disable iff (rst)
        !alloc_en |=> ((row_q & ~$past(row_q)) == '0)); // R7
endmodule

// File: rtl/ldst_hazard_matrix.sv
module ldst_hazard_matrix #(
    parameter int NSLOT     = 8,
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6,
    localparam int IDX_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int TAG_W    = ADDR_W - LINE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic              iss_is_store,
    input  logic [ADDR_W-1:0] iss_addr,
    output logic              iss_stall,
    output logic [IDX_W-1:0]  iss_slot,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_slot,
    output logic [NSLOT-1:0]  slot_busy,
    output logic [NSLOT-1:0]  go_read,
    output logic [NSLOT-1:0]  go_write
);
    logic [NSLOT-1:0] busy_v;
    logic [NSLOT-1:0] store_v;
    logic [TAG_W-1:0] tag_v [NSLOT];
    logic [NSLOT-1:0] row_v [NSLOT];
    logic [NSLOT-1:0] clr_col;
    logic [NSLOT-1:0] new_row;
    logic [TAG_W-1:0] new_tag;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic             accept;

    assign new_tag = iss_addr[ADDR_W-1:LINE_BITS];

    ldst_hm_alloc #(.NSLOT(NSLOT)) u_alloc (
        .busy     (busy_v),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    always_comb begin
        clr_col = '0;
        if (done_valid && (int'(done_slot) < NSLOT)) begin
            clr_col[done_slot] = busy_v[done_slot];
        end
    end

    ldst_hm_cmp #(.NSLOT(NSLOT), .TAG_W(TAG_W)) u_cmp (
        .busy      (busy_v),
        .is_store  (store_v),
        .tags      (tag_v),
        .clr_col   (clr_col),
        .new_store (iss_is_store),
        .new_tag   (new_tag),
        .dep_row   (new_row)
    );

    assign accept    = iss_valid && any_free;
    assign iss_stall = iss_valid && !any_free;
    assign iss_slot  = free_idx;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic alloc_here;
        assign alloc_here = accept && (free_idx == IDX_W'(i));
        ldst_hm_slot #(.NSLOT(NSLOT), .TAG_W(TAG_W)) u_slot (
            .clk         (clk),
            .rst         (rst),
            .alloc_en    (alloc_here),
            .alloc_store (iss_is_store),
            .alloc_tag   (new_tag),
            .alloc_row   (new_row),
            .clr_col     (clr_col),
            .done_hit    (clr_col[i]),
            .busy        (busy_v[i]),
            .is_store    (store_v[i]),
            .tag         (tag_v[i]),
            .row         (row_v[i]),
            .go_rd       (go_read[i]),
            .go_wr       (go_write[i])
        );
    end

    assign slot_busy = busy_v;

    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        iss_stall |-> (&busy_v)); // R9
    AST_STALL_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (iss_stall && !done_valid) |=> (busy_v == $past(busy_v))); // R9
    AST_ISSUE_TAKES_FREE: assert property (@(posedge clk) disable iff (rst)
        accept |-> !busy_v[iss_slot]); // R2
    AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_v[$past(iss_slot)]); // R2

    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NSLOT; i++) begin
                for (int j = 0; j < NSLOT; j++) begin
                    if (row_v[i][j]) begin
                        AST_DEP_OPPOSITE_KIND: assert (busy_v[j] && (store_v[i] != store_v[j])); // R6
                    end
                end
            end
        end
    end
endmodule

// File: tb/ldst_hazard_matrix_bench.sv
`timescale 1ns/1ps
module ldst_hazard_matrix_bench;
    localparam int NSLOT = 8;
    localparam int ADDR_W = 32;
    localparam int IDX_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              iss_valid = 1'b0;
    logic              iss_is_store = 1'b0;
    logic [ADDR_W-1:0] iss_addr = '0;
    logic              iss_stall;
    logic [IDX_W-1:0]  iss_slot;
    logic              done_valid = 1'b0;
    logic [IDX_W-1:0]  done_slot = '0;
    logic [NSLOT-1:0]  slot_busy, go_read, go_write;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [IDX_W-1:0] seen_slot;
    logic             seen_stall;

    always #2.5 clk = ~clk;

    ldst_hazard_matrix u_ldst_hazard_matrix (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_is_store(iss_is_store),
        .iss_addr(iss_addr), .iss_stall(iss_stall), .iss_slot(iss_slot),
        .done_valid(done_valid), .done_slot(done_slot), .slot_busy(slot_busy),
        .go_read(go_read), .go_write(go_write)
    );

    // {is_store, addr, expected slot, expected permission of that slot}
    localparam logic [36:0] VEC [8] = '{
        {1'b0, 32'h0000_1000, 3'd0, 1'b1},  // R2 first load free to go
        {1'b1, 32'h0000_1010, 3'd1, 1'b0},  // R4 store behind load, same line
        {1'b0, 32'h0000_1020, 3'd2, 1'b0},  // R3 load behind store
        {1'b0, 32'h0000_2000, 3'd3, 1'b1},  // R5 other tag
        {1'b1, 32'h0000_2040, 3'd4, 1'b1},  // R5 next line, no match
        {1'b1, 32'h0000_1000, 3'd5, 1'b0},  // R6 waits on loads only
        {1'b0, 32'h0000_3000, 3'd6, 1'b1},
        {1'b0, 32'h0000_3004, 3'd7, 1'b1}   // R6 load-load no dependency
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(bit v, bit st, logic [31:0] a, bit dv, int ds);
        @(negedge clk);
        iss_valid = v; iss_is_store = st; iss_addr = a;
        done_valid = dv; done_slot = IDX_W'(ds);
        #1;
        seen_slot = iss_slot;
        seen_stall = iss_stall;
        @(negedge clk);
        iss_valid = 1'b0; done_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 busy", 32'(slot_busy), 0);
        check("R1 go_read", 32'(go_read), 0);
        check("R1 go_write", 32'(go_write), 0);
        check("R1 stall", 32'(iss_stall), 0);

        for (int k = 0; k < 8; k++) begin
            logic [36:0] v;
            int s;
            v = VEC[k];
            s = int'(v[3:1]);
            step(1'b1, v[36], v[35:4], 1'b0, 0);
            check("R2 slot", 32'(seen_slot), 32'(v[3:1]));
            check("R2 busy", 32'(slot_busy[s]), 1);
            check("R3/R4/R5/R6 permit", 32'(go_read[s] | go_write[s]), 32'(v[0]));
            check("R12 kind", 32'(v[36] ? go_read[s] : go_write[s]), 0);
        end
        check("R12 go_read", 32'(go_read), 32'hC9);
        check("R12 go_write", 32'(go_write), 32'h10);

        step(1'b1, 1'b0, 32'h5000, 1'b0, 0);
        check("R9 stall", 32'(seen_stall), 1);
        check("R9 busy", 32'(slot_busy), 32'hFF);
        check("R9 go_read", 32'(go_read), 32'hC9);

        step(1'b0, 1'b0, 0, 1'b1, 0);
        check("R7 busy", 32'(slot_busy), 32'hFE);
        check("R7 go_write", 32'(go_write), 32'h12);

        step(1'b0, 1'b0, 0, 1'b1, 1);
        check("R8 go_read", 32'(go_read), 32'hCC);
        check("R8 go_write", 32'(go_write), 32'h10);

        step(1'b0, 1'b0, 0, 1'b1, 2);
        check("R7 busy2", 32'(slot_busy), 32'hF8);
        check("R8 go_write2", 32'(go_write), 32'h30);

        step(1'b1, 1'b0, 32'h1008, 1'b1, 5);
        check("R11 slot", 32'(seen_slot), 0);
        check("R11 busy", 32'(slot_busy), 32'hD9);
        check("R11 go_read", 32'(go_read[0]), 1);

        step(1'b0, 1'b0, 0, 1'b1, 1);
        check("R10 busy", 32'(slot_busy), 32'hD9);
        check("R10 go_read", 32'(go_read), 32'hC9);
        check("R10 go_write", 32'(go_write), 32'h10);

        step(1'b1, 1'b1, 32'h103F, 1'b0, 0);
        check("R5 slot", 32'(seen_slot), 1);
        check("R4 blocked", 32'(go_write[1]), 0);
        step(1'b1, 1'b1, 32'h0FFF, 1'b0, 0);
        check("R5 boundary", 32'(go_write[2]), 1);
        check("R5 busy", 32'(slot_busy), 32'hDF);

        @(negedge clk);
        rst = 1'b1; iss_valid = 1'b1; iss_addr = 32'h1000;
        @(negedge clk);
        rst = 1'b0; iss_valid = 1'b0;
        #1;
        check("R1 reset busy", 32'(slot_busy), 0);
        check("R1 reset go", 32'(go_read | go_write), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule